// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds a wall-clock date and time: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A host reaches every field as a byte through a small address/data port. Each one-second pulse on `sec_tick` advances the time. The carry passes from seconds up through the year, and the month limit follows the month and leap year.

Two control bits choose the field encoding and the hour form. The encoding is plain binary or packed BCD. The hour form is 24-hour, or 12-hour with a PM marker in bit 7. A freeze bit stops counting so that software can load a complete, consistent time. While a carry update is pending, a busy status is raised, both on a pin and in a status register. A host write that arrives in that window is held and applied once the update is done.

The host port has no back-pressure. A write strobe is always accepted: at once when the block is idle, or into a one-entry hold slot while busy. Reads are combinational from the address.

Top module: `tod_calendar`

## Requirements
- R1: Register map. The time fields sit at addresses 0 (sec), 2 (min), 4 (hour), 6 (weekday), 7 (day), 8 (month) and 9 (year). Addresses 1, 3 and 5 are plain byte storage that reads back what was written. Address 10 reads bit 7 = busy and all other bits 0, and writes to it have no effect. Address 11 holds bit 7 = freeze, bit 2 = binary and bit 1 = 24-hour, with the other bits reading 0. Addresses 12 to 15 read 0.
- R2: After reset the fields are sec = min = hour = year = 0 and weekday = day = month = 1. Address 11 reads 0x02 (BCD, 24-hour, not frozen), and busy is 0.
- R3: Each accepted tick adds one second. Seconds and minutes run 0–59. On wrap, each passes a carry to the next field. A day carry steps the weekday (1–7) and the day of month. A month carry comes from the day field, and the month (1–12) carries into the year (0–99, then back to 0). A field at or above its limit wraps to its minimum.
- R4: With the binary bit at 0, every field counts in packed BCD (0x09 is followed by 0x10). With the bit at 1, every field counts in plain binary.
- R5: The day-of-month limit is 31, or 30 for months 4, 6, 9 and 11. For month 2 it is 29 when the year value is a multiple of 4 and 28 otherwise.
- R6: In 24-hour mode the hour runs 0–23. The step from 23 to 0 gives the day carry.
- R7: In 12-hour mode the hour value runs 1–12, and bit 7 set means PM. The step from 11 to 12 toggles PM. 12 is followed by 1. The step from 11 PM (0x91 in BCD) to 12 AM gives the day carry.
- R8: While freeze is 1, ticks are ignored, busy stays 0, and field writes take effect on the next clock edge.
- R9: An accepted tick raises busy at the next edge. Busy stays high for UIP_LEAD cycles. The fields change only at the edge where busy falls.
- R10: A host write that arrives while busy is held. It is applied on the first edge after busy falls. If several arrive, the latest one is kept.
- R11: Changing the binary or 12/24-hour bit leaves the stored fields untouched. Counting continues from the old bytes under the new mode.
- R12: A tick that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| host_addr | input | 4 | Register address for read and write |
| host_wr | input | 1 | Write strobe, always accepted |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| upd_busy | output | 1 | Carry update pending |

## Verification
A wrong limit, encoding or carry stays hidden until a field reaches its rollover. The error then shows up in the field readback on the edge where busy falls. For that reason the vector table starts every case one second before a wrap and reads all seven fields right after busy drops. A broken busy window or hold slot shows up in the cycle-exact count of busy samples, and in the value of the seconds field one cycle and two cycles after busy falls. A broken freeze shows as an unwanted busy pulse, or as a stored value that changed.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int N_TOD  = 10;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'd4;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'd6;
  localparam logic [ADDR_W-1:0] A_DAY  = 4'd7;
  localparam logic [ADDR_W-1:0] A_MON  = 4'd8;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd10;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd11;

  // encoded byte -> binary value (7 bits is enough for every field)
  function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // binary value -> encoded byte
  function automatic logic [7:0] from_bin(input logic [6:0] n, input logic bin);
    if (bin) return {1'b0, n};
    return {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction
endpackage

// File: rtl/tod_step.sv
`timescale 1ns/1ps
module tod_step
  import tod_pkg::*;
(
  input  logic [7:0] cur,
  input  logic [6:0] lo,
  input  logic [6:0] hi,
  input  logic       bin,
  input  logic       en,
  output logic [7:0] nxt,
  output logic       wrap
);
  logic [6:0] cb;
  logic       at_top;

  always_comb begin
    cb     = to_bin(cur, bin);
    at_top = (cb >= hi);
    wrap   = en && at_top;
    if (!en)        nxt = cur;
    else if (at_top) nxt = from_bin(lo, bin);
    else            nxt = from_bin(cb + 7'd1, bin);
  end
endmodule

// File: rtl/tod_hour_step.sv
`timescale 1ns/1ps
module tod_hour_step
  import tod_pkg::*;
(
  input  logic [7:0] cur,
  input  logic       bin,
  input  logic       h24,
  input  logic       en,
  output logic [7:0] nxt,
  output logic       wrap
);
  logic [6:0] hb;
  logic [6:0] nh;
  logic [7:0] enc;
  logic       pm;
  logic       npm;
  logic       day;

  always_comb begin
    pm  = cur[7];
    npm = pm;
    day = 1'b0;
    if (h24) begin
      hb  = to_bin(cur, bin);
      day = (hb >= 7'd23);
      nh  = day ? 7'd0 : hb + 7'd1;
      enc = from_bin(nh, bin);
    end else begin
      hb  = to_bin({1'b0, cur[6:0]}, bin);
      nh  = (hb >= 7'd12) ? 7'd1 : hb + 7'd1;
      if (hb == 7'd11) npm = !pm;
      day = (hb == 7'd11) && pm;
      enc = {npm, from_bin(nh, bin)[6:0]};
    end
    nxt  = en ? enc : cur;
    wrap = en && day;
  end
endmodule

// File: rtl/tod_calendar.sv
`timescale 1ns/1ps
module tod_calendar
  import tod_pkg::*;
#(
  parameter int UIP_LEAD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              upd_busy
);
  localparam int CW = (UIP_LEAD < 2) ? 1 : $clog2(UIP_LEAD + 1);

  logic [DATA_W-1:0] fld [N_TOD];
  logic set_q, bin_q, h24_q;
  logic uip_q;
  logic [CW-1:0] wcnt_q;
  logic pend_v;
  logic [ADDR_W-1:0] pend_a;
  logic [DATA_W-1:0] pend_d;

  logic apply_wr;
  logic [ADDR_W-1:0] ap_a;
  logic [DATA_W-1:0] ap_d;
  logic start, upd_fire;

  // write path: held write wins over a fresh one, which is then held
  assign apply_wr = !uip_q && (pend_v || host_wr);
  assign ap_a     = pend_v ? pend_a : host_addr;
  assign ap_d     = pend_v ? pend_d : host_wdata;
  assign start    = sec_tick && !uip_q && !set_q;
  assign upd_fire = uip_q && (wcnt_q == '0);
  assign upd_busy = uip_q;

  // carry chain
  logic [7:0] n_sec, n_min, n_hour, n_wday, n_day, n_mon, n_year;
  logic c_sec, c_min, c_hour, c_wday, c_day, c_mon, c_year;
  logic [6:0] mon_b, yr_b, dim;

  always_comb begin
    mon_b = to_bin(fld[A_MON], bin_q);
    yr_b  = to_bin(fld[A_YEAR], bin_q);
    case (mon_b)
      7'd2:                      dim = (yr_b[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   dim = 7'd30;
      default:                   dim = 7'd31;
    endcase
  end

  tod_step u_sec  (.cur(fld[A_SEC]),  .lo(7'd0), .hi(7'd59), .bin(bin_q), .en(1'b1),
                   .nxt(n_sec),  .wrap(c_sec));
  tod_step u_min  (.cur(fld[A_MIN]),  .lo(7'd0), .hi(7'd59), .bin(bin_q), .en(c_sec),
                   .nxt(n_min),  .wrap(c_min));
  tod_hour_step u_hour (.cur(fld[A_HOUR]), .bin(bin_q), .h24(h24_q), .en(c_min),
                   .nxt(n_hour), .wrap(c_hour));
  tod_step u_wday (.cur(fld[A_WDAY]), .lo(7'd1), .hi(7'd7),  .bin(bin_q), .en(c_hour),
                   .nxt(n_wday), .wrap(c_wday));
  tod_step u_day  (.cur(fld[A_DAY]),  .lo(7'd1), .hi(dim),   .bin(bin_q), .en(c_hour),
                   .nxt(n_day),  .wrap(c_day));
  tod_step u_mon  (.cur(fld[A_MON]),  .lo(7'd1), .hi(7'd12), .bin(bin_q), .en(c_day),
                   .nxt(n_mon),  .wrap(c_mon));
  tod_step u_year (.cur(fld[A_YEAR]), .lo(7'd0), .hi(7'd99), .bin(bin_q), .en(c_mon),
                   .nxt(n_year), .wrap(c_year));

  logic unused_c;
  assign unused_c = c_wday ^ c_year;

  // field storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_TOD; i++) fld[i] <= '0;
      fld[A_WDAY] <= 8'd1;
      fld[A_DAY]  <= 8'd1;
      fld[A_MON]  <= 8'd1;
    end else if (upd_fire) begin
      fld[A_SEC]  <= n_sec;
      fld[A_MIN]  <= n_min;
      fld[A_HOUR] <= n_hour;
      fld[A_WDAY] <= n_wday;
      fld[A_DAY]  <= n_day;
      fld[A_MON]  <= n_mon;
      fld[A_YEAR] <= n_year;
    end else if (apply_wr && (ap_a < ADDR_W'(N_TOD))) begin
      fld[ap_a] <= ap_d;
    end
  end

  // control bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q <= 1'b0; bin_q <= 1'b0; h24_q <= 1'b1;
    end else if (apply_wr && ap_a == A_CTRL) begin
      set_q <= ap_d[7]; bin_q <= ap_d[2]; h24_q <= ap_d[1];
    end
  end

  // update window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip_q  <= 1'b0;
      wcnt_q <= '0;
    end else if (start) begin
      uip_q  <= 1'b1;
      wcnt_q <= CW'(UIP_LEAD - 1);
    end else if (upd_fire) begin
      uip_q  <= 1'b0;
    end else if (uip_q) begin
      wcnt_q <= wcnt_q - 1'b1;
    end
  end

  // one-entry hold slot for writes that meet a busy window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0; pend_a <= '0; pend_d <= '0;
    end else if (host_wr && (uip_q || pend_v)) begin
      pend_v <= 1'b1; pend_a <= host_addr; pend_d <= host_wdata;
    end else if (apply_wr) begin
      pend_v <= 1'b0;
    end
  end

  // read mux
  always_comb begin
    host_rdata = '0;
    if (host_addr < ADDR_W'(N_TOD)) host_rdata = fld[host_addr];
    else if (host_addr == A_STAT)   host_rdata = {uip_q, 7'd0};
    else if (host_addr == A_CTRL)   host_rdata = {set_q, 4'd0, bin_q, h24_q, 1'b0};
  end

  AST_SET_BLOCKS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_q) |-> !$past(set_q)); // R8
  AST_FROZEN_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q && !uip_q && !apply_wr) |=> $stable(fld[A_SEC])); // R8
  AST_UIP_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_q) |-> $past(sec_tick)); // R9
  AST_HOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (uip_q && wcnt_q != '0) |=> $stable(fld[A_SEC])); // R9
  AST_DEFER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (uip_q && host_wr) |=> pend_v); // R10
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (uip_q && wcnt_q != '0) |=> uip_q); // R12
endmodule

// File: tb/tod_calendar_tb.sv
`timescale 1ns/1ps
module tod_calendar_tb;
  localparam int LEAD = 4;
  // {ctrl, sec,min,hour,wday,day,mon,year, expected sec..year}
  localparam logic [119:0] VEC [11] = '{
    120'h02_59_59_23_07_31_12_99_00_00_00_01_01_01_00, // full cascade BCD
    120'h02_09_10_05_03_15_06_21_10_10_05_03_15_06_21, // BCD digit carry
    120'h06_3B_3B_17_03_1C_02_17_00_00_00_04_01_03_17, // binary Feb 28 non-leap
    120'h06_3B_3B_17_03_1C_02_18_00_00_00_04_1D_02_18, // binary Feb 28 leap
    120'h02_59_59_23_05_30_04_20_00_00_00_06_01_05_20, // 30-day month
    120'h00_59_59_11_02_10_03_05_00_00_92_02_10_03_05, // 11AM -> 12PM
    120'h00_59_59_91_02_10_03_05_00_00_12_03_11_03_05, // 11PM -> 12AM + day
    120'h04_3B_3B_8C_02_0A_03_05_00_00_81_02_0A_03_05, // binary 12PM -> 1PM
    120'h06_3B_0A_05_02_0A_03_05_00_0B_05_02_0A_03_05, // binary min carry
    120'h02_59_59_23_07_31_01_07_00_00_00_01_01_02_07, // Jan31 -> Feb1, wday wrap
    120'h02_59_59_23_01_29_02_24_00_00_00_02_01_03_24  // Feb29 leap -> Mar1
  };
  localparam int FADDR [7] = '{0, 2, 4, 6, 7, 8, 9};

  logic clk = 0, rst_n = 0, sec_tick = 0, host_wr = 0;
  logic [3:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic upd_busy;
  int total = 0, bad = 0;
  logic [119:0] cur;
  logic [7:0] d;
  int cnt;

  always #2 clk = ~clk;

  tod_calendar #(.UIP_LEAD(LEAD)) u_dut (.clk, .rst_n, .sec_tick, .host_addr,
    .host_wr, .host_wdata, .host_rdata, .upd_busy);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); host_addr = a; host_wdata = v; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic rd_now(input logic [3:0] a, output logic [7:0] v);
    host_addr = a; #1; v = host_rdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); rd_now(a, v);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    rd(4'd0, d);  chk("R2 sec", d, 8'h00);
    rd(4'd4, d);  chk("R2 hour", d, 8'h00);
    rd(4'd6, d);  chk("R2 wday", d, 8'h01);
    rd(4'd7, d);  chk("R2 day", d, 8'h01);
    rd(4'd8, d);  chk("R2 month", d, 8'h01);
    rd(4'd11, d); chk("R2 ctrl", d, 8'h02);
    rd(4'd10, d); chk("R2 status", d, 8'h00);

    // R3..R7 vector table
    for (int v = 0; v < 11; v++) begin
      cur = VEC[v];
      wr(4'd11, 8'h80 | cur[119:112]);
      for (int k = 0; k < 7; k++) wr(4'(FADDR[k]), cur[111-8*k -: 8]);
      wr(4'd11, cur[119:112]);
      tick();
      while (upd_busy) @(negedge clk);
      for (int k = 0; k < 7; k++) begin
        rd(4'(FADDR[k]), d);
        chk($sformatf("R3 R4 R5 R6 R7 vec%0d field%0d", v, k), d, cur[55-8*k -: 8]);
      end
    end

    // R1 register map
    wr(4'd1, 8'hA5); rd(4'd1, d); chk("R1 alarm storage", d, 8'hA5);
    wr(4'd10, 8'h7F); rd(4'd10, d); chk("R1 status write ignored", d, 8'h00);
    rd(4'd14, d); chk("R1 unused addr", d, 8'h00);
    wr(4'd11, 8'hFF); rd(4'd11, d); chk("R1 ctrl bits", d, 8'h86);

    // R8 freeze: write immediate, tick ignored
    wr(4'd11, 8'h82);
    wr(4'd0, 8'h30); rd(4'd0, d); chk("R8 immediate write", d, 8'h30);
    tick();
    cnt = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (upd_busy) cnt++; end
    chk("R8 no busy when frozen", 8'(cnt), 8'd0);
    rd(4'd0, d); chk("R8 sec frozen", d, 8'h30);

    // R11 mode switch keeps bytes
    wr(4'd0, 8'h25); wr(4'd11, 8'h06);
    rd(4'd0, d); chk("R11 no conversion", d, 8'h25);
    tick(); while (upd_busy) @(negedge clk);
    rd(4'd0, d); chk("R11 binary count from old byte", d, 8'h26);

    // R9 busy window length and field hold
    wr(4'd11, 8'h02); wr(4'd0, 8'h10);
    tick();
    host_addr = 4'd0;
    cnt = 0;
    while (upd_busy && cnt < 20) begin
      rd_now(4'd0, d);
      if (d !== 8'h10) chk("R9 sec held during busy", d, 8'h10);
      cnt++;
      @(negedge clk);
    end
    chk("R9 busy length", 8'(cnt), 8'(LEAD));
    rd_now(4'd0, d); chk("R9 sec after busy", d, 8'h11);

    // R10 deferred write
    tick();
    wr(4'd0, 8'h40);
    while (upd_busy) @(negedge clk);
    rd_now(4'd0, d); chk("R10 update first", d, 8'h12);
    @(negedge clk);
    rd_now(4'd0, d); chk("R10 held write applied", d, 8'h40);

    // R12 second tick during busy ignored
    tick();
    sec_tick = 1; @(negedge clk); sec_tick = 0;
    while (upd_busy) @(negedge clk);
    repeat (LEAD + 2) @(negedge clk);
    rd_now(4'd0, d); chk("R12 single step", d, 8'h41);
    rd_now(4'd10, d); chk("R12 idle after", d, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule